// File: doc/BRIEF.md
# Tone Cadence Classifier

This block sorts telephone call-progress signals into categories by looking only at the rhythm of a 1-bit in-band envelope. The raw envelope is first cleaned by a glitch filter. A level change counts only after it has lasted a set number of timing ticks, so short dropouts and short bursts never reach the rest of the logic.

A rising edge of the cleaned envelope opens a measurement window of fixed length. During the window the block counts every change of the cleaned envelope. When the window closes, the count is turned into a 3-bit category code and held in an output latch, and a valid flag is raised. The result is held until a clear pulse. No new window can start before that pulse. An output enable gates the visible code, the cleaned envelope and the valid flag, in the same way a shared bus gates its drivers.

All timing runs from a one-cycle tick enable, normally once per millisecond. The window length, the filter length and the count thresholds are parameters.

Top module: `tone_cadence_classifier`

## Requirements
- R1: The cleaned envelope changes only on a tick. A raw level that differs from it for IGNORE_TICKS ticks or fewer leaves it unchanged. A raw level that differs for CONFIRM_TICKS consecutive ticks flips it on the CONFIRM_TICKS-th such tick.
- R2: A rising edge of the cleaned envelope opens the window, and `counting` goes high on that same clock edge. `counting` stays high for WINDOW_TICKS ticks and goes low on the clock edge of the WINDOW_TICKS-th tick after opening.
- R3: Only cleaned-envelope changes that occur while the window is open add to the count. The rising edge that opens the window is not counted.
- R4: The code is `code[2:0]`. A count of 0 gives 3'b000 (steady tone). A count from 1 to RING_MAX gives 3'b100 (ringing). A count from RING_MAX+1 to BUSY_MAX gives 3'b010 (busy). A count from BUSY_MAX+1 to REORDER_MAX gives 3'b001 (re-order).
- R5: On the clock edge that closes the window, the code is latched and `data_valid` goes high.
- R6: A count above REORDER_MAX gives the overflow code 3'b111. The internal count saturates, so any number of changes still reports overflow.
- R7: `clear` acts at once and asynchronously. It zeroes the filter, the window, the count and the latch, so `code`, `data_valid`, `env_out` and `counting` all read 0.
- R8: While `out_en` is low, `code`, `env_out` and `data_valid` read 0 and the latched result is kept. `counting` is not gated.
- R9: A steady tone that ends inside the window decodes as ringing (3'b100).
- R10: Once a result is latched, further envelope activity opens no window and leaves the code unchanged until `clear`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clear | input | 1 | Asynchronous clear, active high |
| tick_ms | input | 1 | One-cycle timing tick enable |
| env_raw | input | 1 | Raw in-band envelope |
| out_en | input | 1 | Output enable for code, envelope and valid |
| env_out | output | 1 | Cleaned envelope, gated by out_en |
| code | output | 3 | Latched category code, gated by out_en |
| data_valid | output | 1 | Result latched, gated by out_en |
| counting | output | 1 | Measurement window open |

## Verification
The bench builds the block with a 120-tick window, an 8-tick confirm length and a 4-tick ignore length. The tick arrives every fourth clock. With these values a whole window takes a few hundred cycles, so each count boundary (0, 2, 6, 12 and 13 changes) can be reached by its own synthetic cadence. The default thresholds are kept, so the decoded boundaries are the real ones. The short filter lengths also make it cheap to place dropouts just below the ignore length and to check the exact tick on which the cleaned envelope and the window edges move.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  // Category codes, written as code[2:0]
  typedef enum logic [2:0] {
    CODE_STEADY  = 3'b000,
    CODE_RING    = 3'b100,
    CODE_BUSY    = 3'b010,
    CODE_REORDER = 3'b001,
    CODE_OVF     = 3'b111
  } tcc_code_e;

  // Map a change count onto a category
  function automatic tcc_code_e tcc_classify(input int unsigned n,
                                             input int unsigned ring_max,
                                             input int unsigned busy_max,
                                             input int unsigned reorder_max);
    if (n == 0)                return CODE_STEADY;
    else if (n <= ring_max)    return CODE_RING;
    else if (n <= busy_max)    return CODE_BUSY;
    else if (n <= reorder_max) return CODE_REORDER;
    else                       return CODE_OVF;
  endfunction

endpackage

// File: rtl/tcc_env_qualifier.sv
module tcc_env_qualifier #(
  parameter int unsigned IGNORE_TICKS  = 20,
  parameter int unsigned CONFIRM_TICKS = 40
) (
  input  logic clk,
  input  logic clear,
  input  logic tick,
  input  logic env_raw,
  output logic env_q,
  output logic q_rise,
  output logic q_fall
);

  localparam int unsigned RUN_W = $clog2(CONFIRM_TICKS + 1);

  if (CONFIRM_TICKS <= IGNORE_TICKS) begin : g_bad_lengths
    $error("confirm length must exceed ignore length");
  end

  logic [RUN_W-1:0] run;
  logic             differ;
  logic             flip;

  assign differ = (env_raw != env_q);
  assign flip   = tick && differ && (run == RUN_W'(CONFIRM_TICKS - 1));
  assign q_rise = flip && !env_q;
  assign q_fall = flip && env_q;

  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      env_q <= 1'b0;
      run   <= '0;
    end else if (!differ) begin
      run <= '0;
    end else if (tick) begin
      if (flip) begin
        env_q <= ~env_q;
        run   <= '0;
      end else begin
        run <= run + 1'b1;
      end
    end
  end

endmodule

// File: rtl/tcc_window.sv
module tcc_window #(
  parameter int unsigned WINDOW_TICKS = 2300,
  parameter int unsigned SAT_COUNT    = 13,
  parameter int unsigned CNT_W        = 4
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             tick,
  input  logic             q_rise,
  input  logic             q_fall,
  output logic             counting,
  output logic             win_end,
  output logic [CNT_W-1:0] trans_cnt
);

  localparam int unsigned TW = $clog2(WINDOW_TICKS + 1);

  logic [TW-1:0] tick_cnt;
  logic          done;
  logic          open_win;

  assign win_end  = counting && tick && (tick_cnt == TW'(WINDOW_TICKS - 1));
  assign open_win = q_rise && !counting && !done;

  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      counting  <= 1'b0;
      done      <= 1'b0;
      tick_cnt  <= '0;
      trans_cnt <= '0;
    end else if (open_win) begin
      counting  <= 1'b1;
      tick_cnt  <= '0;
      trans_cnt <= '0;
    end else if (counting) begin
      if (win_end) begin
        counting <= 1'b0;
        done     <= 1'b1;
      end else if (tick) begin
        tick_cnt <= tick_cnt + 1'b1;
      end
      if ((q_rise || q_fall) && trans_cnt != CNT_W'(SAT_COUNT))
        trans_cnt <= trans_cnt + 1'b1;
    end
  end

endmodule

// File: rtl/tcc_result_latch.sv
module tcc_result_latch
  import tcc_pkg::*;
#(
  parameter int unsigned CNT_W       = 4,
  parameter int unsigned RING_MAX    = 2,
  parameter int unsigned BUSY_MAX    = 6,
  parameter int unsigned REORDER_MAX = 12
) (
  input  logic             clk,
  input  logic             clear,
  input  logic             win_end,
  input  logic [CNT_W-1:0] trans_cnt,
  output tcc_code_e        code_lat,
  output logic             valid
);

  tcc_code_e decided;

  assign decided = tcc_classify(32'(trans_cnt), RING_MAX, BUSY_MAX, REORDER_MAX);

  always_ff @(posedge clk or posedge clear) begin
    if (clear) begin
      code_lat <= CODE_STEADY;
      valid    <= 1'b0;
    end else if (win_end) begin
      code_lat <= decided;
      valid    <= 1'b1;
    end
  end

endmodule

// File: rtl/tone_cadence_classifier.sv
module tone_cadence_classifier
  import tcc_pkg::*;
#(
  parameter int unsigned WINDOW_TICKS  = 2300,
  parameter int unsigned IGNORE_TICKS  = 20,
  parameter int unsigned CONFIRM_TICKS = 40,
  parameter int unsigned RING_MAX      = 2,
  parameter int unsigned BUSY_MAX      = 6,
  parameter int unsigned REORDER_MAX   = 12
) (
  input  logic       clk,
  input  logic       clear,
  input  logic       tick_ms,
  input  logic       env_raw,
  input  logic       out_en,
  output logic       env_out,
  output logic [2:0] code,
  output logic       data_valid,
  output logic       counting
);

  localparam int unsigned SAT_COUNT = REORDER_MAX + 1;
  localparam int unsigned CNT_W     = $clog2(SAT_COUNT + 1);

  logic             env_q;
  logic             q_rise;
  logic             q_fall;
  logic             win_open;
  logic             win_end;
  logic [CNT_W-1:0] trans_cnt;
  tcc_code_e        code_lat;
  logic             res_valid;

  tcc_env_qualifier #(
    .IGNORE_TICKS (IGNORE_TICKS),
    .CONFIRM_TICKS(CONFIRM_TICKS)
  ) u_qual (
    .clk    (clk),
    .clear  (clear),
    .tick   (tick_ms),
    .env_raw(env_raw),
    .env_q  (env_q),
    .q_rise (q_rise),
    .q_fall (q_fall)
  );

  tcc_window #(
    .WINDOW_TICKS(WINDOW_TICKS),
    .SAT_COUNT   (SAT_COUNT),
    .CNT_W       (CNT_W)
  ) u_win (
    .clk      (clk),
    .clear    (clear),
    .tick     (tick_ms),
    .q_rise   (q_rise),
    .q_fall   (q_fall),
    .counting (win_open),
    .win_end  (win_end),
    .trans_cnt(trans_cnt)
  );

  tcc_result_latch #(
    .CNT_W      (CNT_W),
    .RING_MAX   (RING_MAX),
    .BUSY_MAX   (BUSY_MAX),
    .REORDER_MAX(REORDER_MAX)
  ) u_res (
    .clk      (clk),
    .clear    (clear),
    .win_end  (win_end),
    .trans_cnt(trans_cnt),
    .code_lat (code_lat),
    .valid    (res_valid)
  );

  assign env_out    = out_en && env_q;
  assign code       = out_en ? code_lat : 3'b000;
  assign data_valid = out_en && res_valid;
  assign counting   = win_open;

endmodule

// File: rtl/tcc_checker.sv
module tcc_checker (
  input logic       clk,
  input logic       clear,
  input logic       tick,
  input logic       out_en,
  input logic       env_q,
  input logic       win_open,
  input logic       win_end,
  input logic       res_valid,
  input logic [2:0] code_lat,
  input logic [2:0] code,
  input logic       data_valid,
  input logic       env_out
);

  // R1
  q_moves_on_tick_chk: assert property (@(posedge clk) disable iff (clear)
    !$stable(env_q) |-> $past(tick));

  // R2
  window_opens_high_chk: assert property (@(posedge clk) disable iff (clear)
    $rose(win_open) |-> env_q);

  // R5
  latch_at_close_chk: assert property (@(posedge clk) disable iff (clear)
    win_end |=> (res_valid && !win_open));

  // R10
  no_reopen_chk: assert property (@(posedge clk) disable iff (clear)
    res_valid |-> !win_open);

  // R8
  gated_outputs_chk: assert property (@(posedge clk) disable iff (clear)
    !out_en |-> (code == 3'b000 && !data_valid && !env_out));

  // R4
  legal_code_chk: assert property (@(posedge clk) disable iff (clear)
    res_valid |-> ($onehot0(code_lat) || code_lat == 3'b111));

  // R7
  always @(posedge clk) begin
    if (clear === 1'b1)
      clear_zeroes_chk: assert (!res_valid && !win_open && !env_q);
  end

endmodule

bind tone_cadence_classifier tcc_checker u_tcc_chk (
  .clk       (clk),
  .clear     (clear),
  .tick      (tick_ms),
  .out_en    (out_en),
  .env_q     (env_q),
  .win_open  (win_open),
  .win_end   (win_end),
  .res_valid (res_valid),
  .code_lat  (code_lat),
  .code      (code),
  .data_valid(data_valid),
  .env_out   (env_out)
);

// File: tb/test_tone_cadence_classifier.sv
`timescale 1ns/1ps
module test_tone_cadence_classifier;

  localparam int W    = 120;
  localparam int IGN  = 4;
  localparam int CONF = 8;

  typedef int seg_q_t[$];

  logic       clk = 1'b0;
  logic       clear;
  logic       tick = 1'b0;
  logic       env_raw = 1'b0;
  logic       out_en = 1'b1;
  logic       env_out;
  logic [2:0] code;
  logic       data_valid;
  logic       counting;

  int vectors = 0;
  int miscompares = 0;
  logic [1:0] div = 2'd0;
  logic [2:0] exp_q[$];
  string      tag_q[$];
  logic       dv_d = 1'b0;

  always #2 clk = ~clk;

  always @(negedge clk) begin
    div  <= div + 2'd1;
    tick <= (div == 2'd3);
  end

  tone_cadence_classifier #(
    .WINDOW_TICKS (W),
    .IGNORE_TICKS (IGN),
    .CONFIRM_TICKS(CONF)
  ) i_tone_cadence_classifier (
    .clk(clk), .clear(clear), .tick_ms(tick), .env_raw(env_raw),
    .out_en(out_en), .env_out(env_out), .code(code),
    .data_valid(data_valid), .counting(counting)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Monitor: pops an expected code on each rise of data_valid
  always @(negedge clk) begin
    dv_d <= data_valid;
    if (data_valid && !dv_d && exp_q.size() != 0) begin
      chk(tag_q.pop_front(), {29'd0, code}, {29'd0, exp_q.pop_front()});
    end
  end

  task automatic wait_ticks(input int n);
    repeat (n) @(posedge clk iff tick == 1'b1);
    #1;
  endtask

  function automatic seg_q_t rep(input int len, input int n);
    seg_q_t q;
    for (int i = 0; i < n; i++) q.push_back(len);
    return q;
  endfunction

  // Independent expectation: count edges of the raw cadence that fall strictly inside the window
  function automatic logic [2:0] expect_code(input seg_q_t s);
    int pos = 0;
    int n = 0;
    for (int i = 0; i < s.size(); i++) begin
      pos += s[i];
      if ((i < s.size() - 1 || (i % 2) == 0) && pos < W) n++;
    end
    case (1'b1)
      (n == 0):  return 3'b000;
      (n < 3):   return 3'b100;
      (n < 7):   return 3'b010;
      (n < 13):  return 3'b001;
      default:   return 3'b111;
    endcase
  endfunction

  task automatic do_clear();
    #1 clear = 1'b1;
    #1 chk("R7 clear code", {29'd0, code}, 32'd0);
    chk("R7 clear valid", {31'd0, data_valid}, 32'd0);
    chk("R7 clear counting", {31'd0, counting}, 32'd0);
    @(negedge clk) clear = 1'b0;
    wait_ticks(CONF + 2);
  endtask

  task automatic wait_result(input string tag);
    int t = 0;
    while (exp_q.size() != 0 && t < 4000) begin
      @(posedge clk);
      t++;
    end
    if (exp_q.size() != 0) begin
      chk({tag, " timeout"}, 32'd0, 32'd1);
      exp_q.delete();
      tag_q.delete();
    end
    #1;
  endtask

  task automatic run_case(input string tag, input seg_q_t s, input logic [2:0] exp);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    for (int i = 0; i < s.size(); i++) begin
      env_raw = ((i % 2) == 0);
      wait_ticks(s[i]);
    end
    env_raw = 1'b0;
    wait_result(tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    seg_q_t s;
    clear = 1'b1;
    repeat (4) @(posedge clk);
    #1;
    chk("R7 reset code", {29'd0, code}, 32'd0);
    chk("R7 reset valid", {31'd0, data_valid}, 32'd0);
    chk("R7 reset env", {31'd0, env_out}, 32'd0);
    @(negedge clk) clear = 1'b0;
    wait_ticks(4);

    // R1: a burst of IGN ticks is ignored
    env_raw = 1'b1; wait_ticks(IGN); env_raw = 1'b0;
    wait_ticks(20);
    chk("R1 burst env", {31'd0, env_out}, 32'd0);
    chk("R1 burst counting", {31'd0, counting}, 32'd0);

    // R1/R2/R5: exact tick of the qualified rise and of the window close
    exp_q.push_back(3'b000); tag_q.push_back("R5 steady code");
    env_raw = 1'b1;
    wait_ticks(CONF - 1);
    chk("R1 env before confirm", {31'd0, env_out}, 32'd0);
    wait_ticks(1);
    chk("R1 env at confirm", {31'd0, env_out}, 32'd1);
    chk("R2 window open", {31'd0, counting}, 32'd1);
    wait_ticks(W - 1);
    chk("R2 still open", {31'd0, counting}, 32'd1);
    chk("R5 valid before close", {31'd0, data_valid}, 32'd0);
    wait_ticks(1);
    chk("R2 closed", {31'd0, counting}, 32'd0);
    chk("R5 valid at close", {31'd0, data_valid}, 32'd1);
    // R10: new activity after the result opens nothing
    env_raw = 1'b0; wait_ticks(20);
    env_raw = 1'b1; wait_ticks(20);
    chk("R10 no reopen", {31'd0, counting}, 32'd0);
    chk("R10 code held", {29'd0, code}, 32'd0);
    chk("R10 valid held", {31'd0, data_valid}, 32'd1);
    env_raw = 1'b0;
    wait_ticks(CONF + 2);
    do_clear();

    // R9: steady tone ending inside the window
    s = {60};
    run_case("R9 end of steady", s, expect_code(s));
    chk("R9 code value", {29'd0, code}, 32'd4);
    do_clear();

    s = {200};
    run_case("R4 steady", s, expect_code(s));
    do_clear();

    s = {50, 50, 40};
    run_case("R4 ring at RING_MAX", s, expect_code(s));
    do_clear();

    s = rep(25, 5);
    run_case("R3 busy", s, expect_code(s));
    do_clear();

    s = rep(18, 7);
    run_case("R4 busy at BUSY_MAX", s, expect_code(s));
    do_clear();

    s = rep(11, 12);
    run_case("R4 reorder", s, expect_code(s));
    do_clear();

    s = rep(9, 12);
    s.push_front(13);
    run_case("R4 reorder at REORDER_MAX", s, expect_code(s));
    do_clear();

    s = rep(9, 16);
    run_case("R6 overflow", s, expect_code(s));
    // R8: enable gating keeps the latched result
    out_en = 1'b0;
    #1;
    chk("R8 gated code", {29'd0, code}, 32'd0);
    chk("R8 gated valid", {31'd0, data_valid}, 32'd0);
    wait_ticks(3);
    out_en = 1'b1;
    #1;
    chk("R8 restored code", {29'd0, code}, 32'd7);
    do_clear();

    s = rep(9, 30);
    run_case("R6 saturated overflow", s, 3'b111);
    do_clear();

    // R1: dropouts of IGN ticks inside a steady tone leave it steady
    s = {30, IGN, 30, IGN, 150};
    run_case("R1 dropouts ignored", s, 3'b000);
    do_clear();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule